// File: doc/BRIEF.md
# E3 Transmit Frame Timing Generator

This block produces the bit-level timing for the transmit side of a 34.368 Mbit/s E3 framer. One frame bit passes per cycle of the line transmit clock. A bit counter walks through the 1536-bit frame, and every bit position is classified as one of the following: alignment word, alarm bit, national bit, justification control bit, justification opportunity bit or payload. The counter is built as four 384-bit sets, using 0-based indices. Bits 0..9 hold the alignment word. Bit 10 is the alarm bit and bit 11 is the national bit. Bits 384..387, 768..771 and 1152..1155 are the justification control bits. Bits 1156..1159 are the justification opportunities. Every other index is payload.

From that classification the block drives two outputs. The first is a gapped clock that a payload source uses to present its data bits. The second is a multi-purpose sync pin. The sync pin can take a frame-start edge from outside, or it can drive out either a frame-start pulse or an overhead indicator. A configuration input decides whether the justification control bits travel with the data stream, and so whether the gapped clock pulses for them. A second configuration input inverts the gapped clock. Configuration inputs are expected to change only while reset is held.

Top module: `e3_tx_timing`

## Requirements
- R1: While `rst_ni` is low, `sync_out_o` is 0 and `gclk_o` equals `gclk_invert_i`. `sync_oe_o` follows the mode in all cases. On the first rising clock edge after reset is released, the counter moves to index 1.
- R2: Unless a sync edge is taken from outside, the counter counts 0..1535 and wraps to 0, so frames repeat every 1536 clock cycles.
- R3: In frame-start mode (`sync_mode_i` = 2'b01), `sync_out_o` is high during indices 0 through 384 inclusive (up to and including the first justification control bit of the second set) and low during the rest of the frame.
- R4: In overhead-indicator mode (`sync_mode_i` = 2'b10 or 2'b11), `sync_out_o` is high exactly during payload indices. It is low during every overhead index, including the justification control bits, whatever `jc_with_data_i` is.
- R5: With `jc_with_data_i` = 0, the gapped clock gives one pulse in each payload bit and none in any overhead bit.
- R6: With `jc_with_data_i` = 1, the gapped clock also pulses during the twelve justification control bits. It never pulses during indices 0..11 or 1156..1159.
- R7: With `gclk_invert_i` = 1, `gclk_o` is the exact complement of the waveform it has when `gclk_invert_i` = 0.
- R8: In external mode (`sync_mode_i` = 2'b00), `sync_in_i` is sampled on the falling clock edge. The bit in which it is first sampled high, after having been sampled low, becomes index 0, so the following bit is index 1. Outputs already launched for that bit are not withdrawn.
- R9: `sync_oe_o` is 0 and `sync_out_o` stays 0 in external mode. `sync_oe_o` is 1 in the three driven modes.
- R10: An external edge that falls on index 0 leaves the frame timing unchanged, with no pulse added or removed.
- R11: In frame-start and overhead-indicator modes, activity on `sync_in_i` has no effect on any output.
- R12: A gapped-clock pulse appears only during the high half of the transmit clock. During the low half, `gclk_o` equals `gclk_invert_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line transmit clock, one frame bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 2 | 00 external frame-start input, 01 frame-start output, 10/11 overhead indicator output |
| jc_with_data_i | input | 1 | 1: justification control bits come with the data stream and are clocked |
| gclk_invert_i | input | 1 | 1: gapped clock is output inverted |
| sync_in_i | input | 1 | External frame-start input, used in mode 00 |
| sync_out_o | output | 1 | Driven frame-start pulse or overhead indicator |
| sync_oe_o | output | 1 | Output enable for the sync pin |
| gclk_o | output | 1 | Gapped payload clock |

## Verification
An external realignment and the choice of the next gapped-clock enable can fall on the same falling edge. The same falling-edge sample that detects the sync edge also has to decide whether the clock pulses in the new index 1. The bench provokes this by raising `sync_in_i` at an arbitrary mid-frame position, and again exactly at index 0. It then compares every subsequent half-cycle of `gclk_o` against a model that restarts at index 1, so a dropped, doubled or misplaced pulse around the reload shows up at once. Frame-start and overhead modes are judged the same way, cycle by cycle, including while `sync_in_i` toggles.

// File: rtl/e3tx_pkg.sv
`timescale 1ns/1ps
package e3tx_pkg;

   // Role of one frame bit position
   typedef enum logic [2:0] {
      BC_ALIGN,
      BC_ALARM,
      BC_NATL,
      BC_JCTRL,
      BC_JOPP,
      BC_PAYLOAD
   } bit_class_e;

   // Function of the sync pin
   typedef enum logic [1:0] {
      SM_EXT_IN    = 2'b00,
      SM_FSTART    = 2'b01,
      SM_OHIND     = 2'b10,
      SM_OHIND_ALT = 2'b11
   } sync_mode_e;

   // Whether the gapped clock may pulse for a bit of class c
   function automatic logic gate_permit(bit_class_e c, logic jc_with_data);
      logic ok;
      case (c)
         BC_PAYLOAD: ok = 1'b1;
         BC_JCTRL:   ok = jc_with_data;
         default:    ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/e3tx_bit_class.sv
`timescale 1ns/1ps
// Maps a frame bit index onto its role using per-set range compares.
module e3tx_bit_class #(
   parameter int SET_BITS  = 384,
   parameter int NUM_SETS  = 4,
   parameter int ALIGN_LEN = 10,
   parameter int JC_LEN    = 4,
   parameter int JOPP_LEN  = 4,
   parameter int CNT_W     = 11
) (
   input  logic [CNT_W-1:0]      pos_i,
   output e3tx_pkg::bit_class_e  cls_o
);

   localparam logic [CNT_W-1:0] ALARM_POS = CNT_W'(ALIGN_LEN);
   localparam logic [CNT_W-1:0] NATL_POS  = CNT_W'(ALIGN_LEN + 1);

   logic [NUM_SETS-1:0] jc_hit;
   logic [NUM_SETS-1:0] jo_hit;

   // Set I carries no justification bits
   assign jc_hit[0] = 1'b0;
   assign jo_hit[0] = 1'b0;

   for (genvar s = 1; s < NUM_SETS; s++) begin : g_set
      localparam logic [CNT_W-1:0] BASE   = CNT_W'(s * SET_BITS);
      localparam logic [CNT_W-1:0] JC_END = CNT_W'(s * SET_BITS + JC_LEN);
      localparam logic [CNT_W-1:0] JO_END = CNT_W'(s * SET_BITS + JC_LEN + JOPP_LEN);

      assign jc_hit[s] = (pos_i >= BASE) && (pos_i < JC_END);

      if (s == NUM_SETS - 1) begin : g_last
         // Only the final set follows its control bits with opportunities
         assign jo_hit[s] = (pos_i >= JC_END) && (pos_i < JO_END);
      end else begin : g_mid
         assign jo_hit[s] = 1'b0;
      end
   end

   always_comb begin
      if (pos_i < ALARM_POS) begin
         cls_o = e3tx_pkg::BC_ALIGN;
      end else if (pos_i == ALARM_POS) begin
         cls_o = e3tx_pkg::BC_ALARM;
      end else if (pos_i == NATL_POS) begin
         cls_o = e3tx_pkg::BC_NATL;
      end else if (|jc_hit) begin
         cls_o = e3tx_pkg::BC_JCTRL;
      end else if (|jo_hit) begin
         cls_o = e3tx_pkg::BC_JOPP;
      end else begin
         cls_o = e3tx_pkg::BC_PAYLOAD;
      end
   end

endmodule

// File: rtl/e3tx_bit_counter.sv
`timescale 1ns/1ps
// Frame bit counter with wrap and synchronous reload to index 1.
module e3tx_bit_counter #(
   parameter int FRAME_BITS = 1536,
   parameter int CNT_W      = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] succ_o,
   output logic [CNT_W-1:0] next_o
);

   localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   // Plain successor, ignoring any reload request
   assign succ_o = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
   assign next_o = load_i ? RELOAD : succ_o;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= next_o;
      end
   end

endmodule

// File: rtl/e3tx_sync_port.sv
`timescale 1ns/1ps
// Sync pin: falling-edge capture of the external edge, registered output.
module e3tx_sync_port #(
   parameter int SET_BITS = 384,
   parameter int CNT_W    = 11
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [1:0]           mode_i,
   input  logic                 sync_in_i,
   input  logic [CNT_W-1:0]     next_pos_i,
   input  e3tx_pkg::bit_class_e next_cls_i,
   output logic                 rise_o,
   output logic                 load_o,
   output logic                 sync_out_o,
   output logic                 sync_oe_o
);

   // Frame-start pulse stays up through the first control bit of set II
   localparam logic [CNT_W-1:0] FS_LAST = CNT_W'(SET_BITS);

   logic smp_q;
   logic load_q;
   logic level_d;
   logic out_q;
   logic ext_mode;

   assign ext_mode = (mode_i == e3tx_pkg::SM_EXT_IN);

   // Edge as seen by this falling-edge sample against the previous one
   assign rise_o = ext_mode & sync_in_i & ~smp_q;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         smp_q  <= 1'b0;
         load_q <= 1'b0;
      end else begin
         smp_q  <= sync_in_i;
         load_q <= rise_o;
      end
   end

   always_comb begin
      case (mode_i)
         e3tx_pkg::SM_FSTART:    level_d = (next_pos_i <= FS_LAST);
         e3tx_pkg::SM_OHIND,
         e3tx_pkg::SM_OHIND_ALT: level_d = (next_cls_i == e3tx_pkg::BC_PAYLOAD);
         default:                level_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q <= 1'b0;
      end else begin
         out_q <= level_d;
      end
   end

   assign load_o     = load_q;
   assign sync_out_o = out_q;
   assign sync_oe_o  = ~ext_mode;

endmodule

// File: rtl/e3tx_gap_clock.sv
`timescale 1ns/1ps
// Gapped clock: enable captured on the falling edge, ANDed with the clock.
module e3tx_gap_clock #(
   parameter bit INV_SUPPORT = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 jc_with_data_i,
   input  logic                 invert_i,
   input  e3tx_pkg::bit_class_e up_cls_i,
   output logic                 en_o,
   output logic                 gclk_o
);

   logic en_q;
   logic gated;

   // The enable changes only while the clock is low, so the AND is clean
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= 1'b0;
      end else begin
         en_q <= e3tx_pkg::gate_permit(up_cls_i, jc_with_data_i);
      end
   end

   assign gated = clk_i & en_q;
   assign en_o  = en_q;

   if (INV_SUPPORT) begin : g_polarity
      assign gclk_o = gated ^ invert_i;
   end else begin : g_fixed
      assign gclk_o = gated;
   end

endmodule

// File: rtl/e3_tx_timing.sv
`timescale 1ns/1ps
// E3 transmit frame timing generator, top level.
module e3_tx_timing #(
   parameter int SET_BITS  = 384,
   parameter int NUM_SETS  = 4,
   parameter int ALIGN_LEN = 10,
   parameter int JC_LEN    = 4,
   parameter int JOPP_LEN  = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sync_mode_i,
   input  logic       jc_with_data_i,
   input  logic       gclk_invert_i,
   input  logic       sync_in_i,
   output logic       sync_out_o,
   output logic       sync_oe_o,
   output logic       gclk_o
);

   localparam int FRAME_BITS = SET_BITS * NUM_SETS;
   localparam int CNT_W      = $clog2(FRAME_BITS);

   // Elaboration-time parameter checks
   if (NUM_SETS < 2) begin : g_bad_sets
      $error("e3_tx_timing: NUM_SETS must be at least 2");
   end
   if (ALIGN_LEN + 2 >= SET_BITS) begin : g_bad_align
      $error("e3_tx_timing: alignment header does not fit a set");
   end
   if (JC_LEN < 1 || JC_LEN + JOPP_LEN >= SET_BITS) begin : g_bad_jc
      $error("e3_tx_timing: justification field sizes out of range");
   end

   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     succ_pos;
   logic [CNT_W-1:0]     next_pos;
   logic [CNT_W-1:0]     gate_pos;
   logic                 ext_rise;
   logic                 ext_load;
   logic                 gate_en;
   e3tx_pkg::bit_class_e next_cls;
   e3tx_pkg::bit_class_e gate_cls;

   e3tx_bit_counter #(
      .FRAME_BITS (FRAME_BITS),
      .CNT_W      (CNT_W)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ext_load),
      .cnt_o  (cnt_q),
      .succ_o (succ_pos),
      .next_o (next_pos)
   );

   // Position the coming bit will have, seen from the falling edge
   assign gate_pos = ext_rise ? CNT_W'(1) : succ_pos;

   e3tx_bit_class #(
      .SET_BITS  (SET_BITS),
      .NUM_SETS  (NUM_SETS),
      .ALIGN_LEN (ALIGN_LEN),
      .JC_LEN    (JC_LEN),
      .JOPP_LEN  (JOPP_LEN),
      .CNT_W     (CNT_W)
   ) u_cls_gate (
      .pos_i (gate_pos),
      .cls_o (gate_cls)
   );

   e3tx_bit_class #(
      .SET_BITS  (SET_BITS),
      .NUM_SETS  (NUM_SETS),
      .ALIGN_LEN (ALIGN_LEN),
      .JC_LEN    (JC_LEN),
      .JOPP_LEN  (JOPP_LEN),
      .CNT_W     (CNT_W)
   ) u_cls_next (
      .pos_i (next_pos),
      .cls_o (next_cls)
   );

   e3tx_sync_port #(
      .SET_BITS (SET_BITS),
      .CNT_W    (CNT_W)
   ) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (sync_mode_i),
      .sync_in_i  (sync_in_i),
      .next_pos_i (next_pos),
      .next_cls_i (next_cls),
      .rise_o     (ext_rise),
      .load_o     (ext_load),
      .sync_out_o (sync_out_o),
      .sync_oe_o  (sync_oe_o)
   );

   e3tx_gap_clock #(
      .INV_SUPPORT (1'b1)
   ) u_gclk (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .jc_with_data_i (jc_with_data_i),
      .invert_i       (gclk_invert_i),
      .up_cls_i       (gate_cls),
      .en_o           (gate_en),
      .gclk_o         (gclk_o)
   );

endmodule

// File: rtl/e3_tx_timing_chk.sv
`timescale 1ns/1ps
// Property checker bound into the timing generator.
module e3_tx_timing_chk #(
   parameter int SET_BITS  = 384,
   parameter int NUM_SETS  = 4,
   parameter int ALIGN_LEN = 10,
   parameter int JC_LEN    = 4,
   parameter int JOPP_LEN  = 4,
   parameter int CNT_W     = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [1:0]       sync_mode_i,
   input logic             jc_with_data_i,
   input logic             sync_out_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic             gate_en,
   input logic             ext_load
);

   localparam logic [CNT_W-1:0] LAST    = CNT_W'(SET_BITS * NUM_SETS - 1);
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(ALIGN_LEN + 2);
   localparam logic [CNT_W-1:0] FS_LAST = CNT_W'(SET_BITS);
   localparam logic [CNT_W-1:0] JC1_LO  = CNT_W'(SET_BITS);
   localparam logic [CNT_W-1:0] JC1_HI  = CNT_W'(SET_BITS + JC_LEN);
   localparam logic [CNT_W-1:0] JO_LO   = CNT_W'((NUM_SETS - 1) * SET_BITS + JC_LEN);
   localparam logic [CNT_W-1:0] JO_HI   = CNT_W'((NUM_SETS - 1) * SET_BITS + JC_LEN + JOPP_LEN);

   p_cnt_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_load && cnt_q == LAST) |=> (cnt_q == '0));

   p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_load && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_load |=> (cnt_q == CNT_W'(1)));

   p_hdr_gap_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (cnt_q < HDR_END) |-> !gate_en);

   p_jopp_gap_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (cnt_q >= JO_LO && cnt_q < JO_HI) |-> !gate_en);

   p_jc_gap_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!jc_with_data_i && cnt_q >= JC1_LO && cnt_q < JC1_HI) |-> !gate_en);

   p_fs_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_mode_i == 2'b01 && cnt_q != '0 && cnt_q <= FS_LAST) |-> sync_out_o);

   p_fs_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_mode_i == 2'b01 && cnt_q > FS_LAST) |-> !sync_out_o);

   p_oh_hdr_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_mode_i[1] && cnt_q < HDR_END) |-> !sync_out_o);

   p_ext_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_mode_i == 2'b00) |-> !sync_out_o);

endmodule

bind e3_tx_timing e3_tx_timing_chk #(
   .SET_BITS  (SET_BITS),
   .NUM_SETS  (NUM_SETS),
   .ALIGN_LEN (ALIGN_LEN),
   .JC_LEN    (JC_LEN),
   .JOPP_LEN  (JOPP_LEN),
   .CNT_W     (CNT_W)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .sync_mode_i    (sync_mode_i),
   .jc_with_data_i (jc_with_data_i),
   .sync_out_o     (sync_out_o),
   .cnt_q          (cnt_q),
   .gate_en        (gate_en),
   .ext_load       (ext_load)
);

// File: tb/tb_e3_tx_timing.sv
`timescale 1ns/1ps
module tb_e3_tx_timing;

   localparam int FRAME = 1536;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b01;
   logic       cfg_jcd = 1'b0;
   logic       cfg_inv = 1'b0;
   logic       sync_in = 1'b0;
   logic       sync_out;
   logic       sync_oe;
   logic       gclk;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;
   int ref_pos  = 0;
   logic prev_s = 1'b0;

   typedef struct {
      logic  gate;
      logic  sync;
      logic  oe;
      logic  inv;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;

   e3_tx_timing dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .sync_mode_i    (cfg_mode),
      .jc_with_data_i (cfg_jcd),
      .gclk_invert_i  (cfg_inv),
      .sync_in_i      (sync_in),
      .sync_out_o     (sync_out),
      .sync_oe_o      (sync_oe),
      .gclk_o         (gclk)
   );

   // Reference bit map taken from the requirements
   function automatic bit is_jc(int p);
      return (p >= 384 && p < 388) || (p >= 768 && p < 772) || (p >= 1152 && p < 1156);
   endfunction

   function automatic bit is_pay(int p);
      return !(p < 12) && !is_jc(p) && !(p >= 1156 && p < 1160);
   endfunction

   function automatic logic exp_gate(int p, logic jcd);
      return is_pay(p) || (jcd && is_jc(p));
   endfunction

   function automatic logic exp_sync(int p, logic [1:0] m);
      logic v;
      case (m)
         2'b01:   v = (p <= 384);
         2'b10,
         2'b11:   v = is_pay(p);
         default: v = 1'b0;
      endcase
      return v;
   endfunction

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Driver: one bit period, pushes the expected outputs for that bit
   task automatic step(input logic s, input string tag);
      exp_t it;
      @(posedge clk);
      #2;
      sync_in = s;
      it.gate = exp_gate(ref_pos, cfg_jcd);
      it.sync = exp_sync(ref_pos, cfg_mode);
      it.oe   = (cfg_mode != 2'b00);
      it.inv  = cfg_inv;
      it.tag  = tag;
      sb_q.push_back(it);
      if (cfg_mode == 2'b00 && s && !prev_s) ref_pos = 1;
      else ref_pos = (ref_pos + 1) % FRAME;
      prev_s = s;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, tag);
   endtask

   task automatic do_reset(input logic [1:0] m, input logic jcd, input logic inv);
      @(posedge clk);
      #2;
      rst_n    = 1'b0;
      sync_in  = 1'b0;
      cfg_mode = m;
      cfg_jcd  = jcd;
      cfg_inv  = inv;
      @(posedge clk);
      #5;
      // R1: reset state seen at the ports
      chk("R1", "sync_out in reset", sync_out, 1'b0);
      chk("R1", "gclk in reset", gclk, inv);
      chk("R1 R9", "sync_oe in reset", sync_oe, m != 2'b00);
      @(posedge clk);
      #2;
      rst_n   = 1'b1;
      ref_pos = 1;
      prev_s  = 1'b0;
   endtask

   // Monitor: pops one expected item per bit and compares both clock halves
   initial begin
      exp_t it;
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            chk(it.tag, "gclk high half", gclk, it.gate ^ it.inv);
            chk(it.tag, "sync_out", sync_out, it.sync);
            chk("R9", "sync_oe", sync_oe, it.oe);
            #10;
            chk("R12", "gclk low half", gclk, it.inv);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      // Frame-start output, control bits gapped
      do_reset(2'b01, 1'b0, 1'b0);
      run(3100, "R2 R3 R5 R6");

      // Overhead indicator, control bits clocked
      do_reset(2'b10, 1'b1, 1'b0);
      run(1600, "R4 R6");

      // Inverted gapped clock
      do_reset(2'b01, 1'b1, 1'b1);
      run(1600, "R7 R3");

      // External sync: free run, misaligned edge, then an aligned edge
      do_reset(2'b00, 1'b1, 1'b0);
      run(700, "R2 R9");
      step(1'b1, "R8");
      step(1'b1, "R8");
      step(1'b1, "R8");
      run(1600, "R8");
      while (ref_pos != 0) step(1'b0, "R8");
      step(1'b1, "R10");
      run(1600, "R10");

      // External sync with control bits gapped and inverted output
      do_reset(2'b00, 1'b0, 1'b1);
      run(213, "R8");
      step(1'b1, "R8");
      run(1600, "R8 R5");

      // Sync input toggling in driven modes is ignored
      do_reset(2'b01, 1'b0, 1'b0);
      for (int i = 0; i < 2000; i++) step((i % 7) == 3, "R11");
      do_reset(2'b11, 1'b0, 1'b0);
      for (int i = 0; i < 1700; i++) step((i % 5) == 1, "R11 R4");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule